// File: doc/BRIEF.md
# FIFO Fill Level Phase Detector

This block measures where a transmit clock sits relative to the midpoint of an elastic FIFO. It watches the FIFO's one-bit half-full flag, which lives in the transmit clock domain. Over a window of a programmed number of transmit-clock cycles, it counts the cycles in which the flag is high. When the window closes it raises a sticky done flag in the system clock domain and presents the count there. A clock sitting on the FIFO midpoint gives a count of about half the window length, so a control loop can step the clock phase until the count reaches that value.

The system-domain reset doubles as the clear that starts a new measurement. The clear is carried into the transmit domain through a request/echo exchange, so even a one-cycle pulse restarts the window from zero. The frozen count comes back to the system domain behind a synchronised ready flag, so the 32-bit value is never sampled while it is changing. The window length is treated as static, and a clear must follow any change to it.

Top module: `fifo_phase_detector`

## Requirements
- R1: While reset is high, and after it until a measurement completes, `done_o` reads 0 and `count_o` reads 0.
- R2: With the half-full flag held high for the whole window, the result equals the programmed window length `win_len`.
- R3: Once `done_o` is 1 it stays 1 until the next reset/clear, whatever the half-full flag does.
- R4: While `done_o` is 1, `count_o` does not change.
- R5: A reset pulse of a single system cycle drops `done_o` and `count_o` to 0 at the next system edge. It then starts a fresh measurement, which uses the window length present at that time.
- R6: A window length of 0 acts as a length of 1, so a flag held high gives a result of 1.
- R7: Only cycles with the flag high are counted: a flag held low gives 0, and a flag high in one transmit cycle of every four gives exactly `win_len`/4 when `win_len` is a multiple of 4.
- R8: A flag that alternates every transmit cycle (the midpoint case) gives exactly `win_len`/2 for an even `win_len`.
- R9: After reset falls, `done_o` stays 0 for at least `win_len` transmit cycles. It rises no later than `win_len`+8 transmit cycles plus 24 system cycles after reset falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock |
| sys_rst | input | 1 | Synchronous active-high reset; also the measurement clear |
| tx_clk | input | 1 | Transmit clock |
| half_full | input | 1 | FIFO half-full flag, synchronous to `tx_clk` |
| win_len | input | CNT_W | Window length in transmit cycles (static between clears) |
| done_o | output | 1 | Sticky measurement-complete flag (system domain) |
| count_o | output | CNT_W | Number of flagged cycles in the window (system domain) |

## Verification
The result is due at a time that depends on two clocks, not at a fixed cycle. After each clear the bench samples `done_o` at the first system falling edge after `win_len` transmit periods have passed, and expects 0 there. It then polls at every system falling edge up to the R9 bound, and the first cycle in which `done_o` is 1 is taken as the arrival. The count is compared at that arrival and again 50 system cycles later. For the clear, the bench checks both outputs at the falling edge right after the single rising edge that sees reset high.

// File: rtl/fpd_pkg.sv
package fpd_pkg;
  localparam int unsigned FPD_SYNC_DEPTH = 2;

  typedef enum logic [1:0] {
    CLR_FLUSH = 2'd0,
    CLR_HOLD  = 2'd1,
    CLR_DRAIN = 2'd2,
    MEAS_RUN  = 2'd3
  } fpd_clr_state_e;
endpackage

// File: rtl/fpd_sync.sv
module fpd_sync #(
  parameter int unsigned STAGES  = 2,
  parameter bit          HAS_RST = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (HAS_RST) begin : g_rst
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
      end
    end else begin : g_norst
      always_ff @(posedge clk) begin
        chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/fpd_tx_accum.sv
module fpd_tx_accum #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             tx_clk,
  input  logic             clr,
  input  logic             flag,
  input  logic [CNT_W-1:0] win_len,
  output logic             ready,
  output logic [CNT_W-1:0] hold_cnt
);
  logic [CNT_W-1:0] win_cnt;
  logic [CNT_W-1:0] ones_cnt;
  logic [CNT_W-1:0] win_nx;
  logic [CNT_W-1:0] ones_nx;
  logic             last;

  always_comb begin
    win_nx  = win_cnt + 1'b1;
    ones_nx = ones_cnt + {{(CNT_W-1){1'b0}}, flag};
    last    = (win_nx == win_len) || (win_len == '0);
  end

  always_ff @(posedge tx_clk) begin
    if (clr) begin
      win_cnt  <= '0;
      ones_cnt <= '0;
      ready    <= 1'b0;
      hold_cnt <= '0;
    end else if (!ready) begin
      win_cnt  <= win_nx;
      ones_cnt <= ones_nx;
      if (last) begin
        ready    <= 1'b1;
        hold_cnt <= ones_nx;
      end
    end
  end
endmodule

// File: rtl/fpd_sys_ctrl.sv
module fpd_sys_ctrl
  import fpd_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             echo,
  input  logic             ready_s,
  input  logic [CNT_W-1:0] hold_cnt,
  output logic             req,
  output logic             done,
  output logic [CNT_W-1:0] result
);
  fpd_clr_state_e st;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= CLR_FLUSH;
      req    <= 1'b0;
      done   <= 1'b0;
      result <= '0;
    end else begin
      case (st)
        CLR_FLUSH: if (!echo) begin
          st  <= CLR_HOLD;
          req <= 1'b1;
        end
        CLR_HOLD: if (echo) begin
          st  <= CLR_DRAIN;
          req <= 1'b0;
        end
        CLR_DRAIN: if (!echo) st <= MEAS_RUN;
        MEAS_RUN: if (ready_s && !done) begin
          done   <= 1'b1;
          result <= hold_cnt;
        end
        default: st <= CLR_FLUSH;
      endcase
    end
  end
endmodule

// File: rtl/fifo_phase_detector.sv
module fifo_phase_detector
  import fpd_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             sys_clk,
  input  logic             sys_rst,
  input  logic             tx_clk,
  input  logic             half_full,
  input  logic [CNT_W-1:0] win_len,
  output logic             done_o,
  output logic [CNT_W-1:0] count_o
);
  logic             clr_req;
  logic             clr_tx;
  logic             clr_echo;
  logic             tx_ready;
  logic             ready_sys;
  logic [CNT_W-1:0] tx_hold;

  fpd_sync #(.STAGES(FPD_SYNC_DEPTH), .HAS_RST(1'b0)) u_req_sync (
    .clk(tx_clk), .rst(1'b0), .d(clr_req), .q(clr_tx)
  );

  fpd_sync #(.STAGES(FPD_SYNC_DEPTH), .HAS_RST(1'b1)) u_echo_sync (
    .clk(sys_clk), .rst(sys_rst), .d(clr_tx), .q(clr_echo)
  );

  fpd_sync #(.STAGES(FPD_SYNC_DEPTH), .HAS_RST(1'b1)) u_rdy_sync (
    .clk(sys_clk), .rst(sys_rst), .d(tx_ready), .q(ready_sys)
  );

  fpd_tx_accum #(.CNT_W(CNT_W)) u_accum (
    .tx_clk  (tx_clk),
    .clr     (clr_tx),
    .flag    (half_full),
    .win_len (win_len),
    .ready   (tx_ready),
    .hold_cnt(tx_hold)
  );

  fpd_sys_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk     (sys_clk),
    .rst     (sys_rst),
    .echo    (clr_echo),
    .ready_s (ready_sys),
    .hold_cnt(tx_hold),
    .req     (clr_req),
    .done    (done_o),
    .result  (count_o)
  );
endmodule

// File: rtl/fpd_check.sv
module fpd_check #(
  parameter int unsigned CNT_W = 32
) (
  input logic             sys_clk,
  input logic             sys_rst,
  input logic [CNT_W-1:0] win_len,
  input logic             done_o,
  input logic [CNT_W-1:0] count_o
);
  AST_DONE_STICKY: assert property (@(posedge sys_clk) disable iff (sys_rst)
    done_o |=> done_o); // R3

  AST_RESULT_HOLD: assert property (@(posedge sys_clk) disable iff (sys_rst)
    done_o |=> $stable(count_o)); // R4

  AST_CLEAR_EFFECT: assert property (@(posedge sys_clk)
    sys_rst |=> (!done_o && count_o == '0)); // R5

  AST_RESULT_BOUND: assert property (@(posedge sys_clk) disable iff (sys_rst)
    done_o |-> (count_o <= ((win_len == '0) ? 1 : win_len))); // R2

  AST_IDLE_ZERO: assert property (@(posedge sys_clk) disable iff (sys_rst)
    !done_o |-> (count_o == '0)); // R1
endmodule

bind fifo_phase_detector fpd_check #(.CNT_W(CNT_W)) u_fpd_check (
  .sys_clk(sys_clk),
  .sys_rst(sys_rst),
  .win_len(win_len),
  .done_o (done_o),
  .count_o(count_o)
);

// File: tb/tb_fifo_phase_detector.sv
`timescale 1ns/1ps
module tb_fifo_phase_detector;
  localparam int CW = 32;
  localparam real TSYS = 10.0;
  localparam real TTX  = 7.0;

  logic          sys_clk = 1'b0;
  logic          tx_clk  = 1'b0;
  logic          sys_rst = 1'b1;
  logic          half_full = 1'b0;
  logic [CW-1:0] win_len = 32'd16;
  logic          done_o;
  logic [CW-1:0] count_o;

  int checks = 0;
  int fails  = 0;
  int mode   = 0; // 0 low, 1 high, 2 alternate, 3 one-in-four
  int phase  = 0;

  always #(TSYS/2) sys_clk = ~sys_clk;
  always #(TTX/2)  tx_clk  = ~tx_clk;

  fifo_phase_detector #(.CNT_W(CW)) dut (
    .sys_clk(sys_clk), .sys_rst(sys_rst), .tx_clk(tx_clk),
    .half_full(half_full), .win_len(win_len),
    .done_o(done_o), .count_o(count_o)
  );

  always @(negedge tx_clk) begin
    phase <= (phase + 1) % 4;
    case (mode)
      0: half_full <= 1'b0;
      1: half_full <= 1'b1;
      2: half_full <= phase[0];
      default: half_full <= (phase == 0);
    endcase
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // clear, measure, check lower bound, arrival, value, stability
  task automatic measure(input int n, input int m, input longint exp, input string req);
    int limit;
    bit seen;
    longint first;
    mode = m;
    @(negedge sys_clk);
    win_len = n;
    sys_rst = 1'b1;
    repeat (3) @(negedge sys_clk);
    sys_rst = 1'b0;
    #(TTX * n);
    @(negedge sys_clk);
    chk(done_o == 1'b0, "R9 early", done_o, 0);
    limit = int'((TTX * (n + 8)) / TSYS) + 24;
    seen = 0;
    for (int i = 0; i < limit && !seen; i++) begin
      @(negedge sys_clk);
      if (done_o) seen = 1;
    end
    chk(seen, "R9 late", seen, 1);
    first = count_o;
    chk(count_o == exp, req, count_o, exp);
    repeat (50) @(negedge sys_clk);
    chk(done_o == 1'b1, "R3", done_o, 1);
    chk(count_o == first, "R4", count_o, first);
  endtask

  task automatic pulse_clear();
    @(negedge sys_clk);
    sys_rst = 1'b1;
    @(negedge sys_clk);
    sys_rst = 1'b0;
    chk(done_o == 1'b0, "R5 done", done_o, 0);
    chk(count_o == 0, "R5 count", count_o, 0);
  endtask

  initial begin
    repeat (4) @(negedge sys_clk);
    chk(done_o == 1'b0, "R1 done", done_o, 0);
    chk(count_o == 0, "R1 count", count_o, 0);
    sys_rst = 1'b0;
    repeat (3) @(negedge sys_clk);
    chk(done_o == 1'b0 && count_o == 0, "R1 after", count_o, 0);

    measure(64, 1, 64, "R2 all high");
    measure(100, 0, 0, "R7 all low");
    measure(200, 3, 50, "R7 quarter");
    measure(1000, 2, 500, "R8 midpoint");
    measure(0, 1, 1, "R6 zero len");
    measure(1, 1, 1, "R6 len one");

    // single-cycle clear with a new length starts a fresh window (R5)
    mode = 1;
    win_len = 40;
    pulse_clear();
    begin
      bit seen = 0;
      for (int i = 0; i < 200 && !seen; i++) begin
        @(negedge sys_clk);
        if (done_o) seen = 1;
      end
      chk(seen && count_o == 40, "R5 restart", count_o, 40);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule